// File: doc/BRIEF.md
# Video Clock and Subcarrier Phase Generator

This block turns one master video clock into every timing reference a small video display processor needs. A single free-running counter, clocked on the rising edge, produces three single-cycle enables. The dot enable fires every second master cycle, the CPU enable every third, and the graphics ROM enable every twenty-fourth. The three enables are aligned on one common cycle.

The same counter, taken modulo three, feeds a six-phase color subcarrier generator. A second register on the falling master edge copies that count. Each of the six outputs is formed from one rising-edge state and one falling-edge state. The result is six square waves at one third of the master rate, each high for half its period and spaced 60 degrees apart.

A color code is captured once per dot. Codes that name a chroma color route one fixed subcarrier phase to the chroma output. Every code, including the grays, also gives a gray-scale luma level, so the picture stays readable on a monochrome receiver. A burst gate passes the reference phase while the caller's burst window is open.

Top module: `vcp_clockgen`

## Requirements
- R1: `dot_en` is high during the first master cycle after the first rising edge that follows reset release. It then repeats every 2 master cycles and is low otherwise.
- R2: `cpu_en` is high during that same first cycle. It then repeats every 3 master cycles and is low otherwise.
- R3: `rom_en` is high during that same first cycle. It then repeats every 24 master cycles, and whenever it is high, `dot_en` and `cpu_en` are also high.
- R4: Half-cycles are numbered from 0, starting at the first rising edge after reset release, and counted modulo 6. Output `sc_phase[k]` is high in half-cycles k, k+1 and k+2 (mod 6) and low in the other three. At every instant exactly three phase bits are high.
- R5: While `rst_n` is low, and after its release until the first rising edge, every output is low. This includes `luma`, which reads 0 because the held code is reset to 0.
- R6: `color_code` is loaded only on a rising edge where `dot_en` is high. `luma`, `chroma_on` and `chroma_out` follow the loaded code from that edge on, and a change of `color_code` at any other edge has no effect.
- R7: Loaded codes 1 through 6 are chroma colors. Code c drives `chroma_on` high, and `chroma_out` follows `sc_phase[c-1]`.
- R8: Loaded codes 0 and 7 through 15 drive `chroma_on` low and hold `chroma_out` low.
- R9: The luma level for each code is: 0 gives 0, 1 gives 6, 2 gives 9, 3 gives 4, 4 gives 11, 5 gives 7, 6 gives 5, 7 gives 15. A code g from 8 to 15 gives 2*(g-8)+1.
- R10: `burst_out` equals `sc_phase[3]` while `burst_win` is high and is low while `burst_win` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master video clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| color_code | input | 4 | Color code, sampled on dot enable |
| burst_win | input | 1 | Burst window from the sync logic |
| dot_en | output | 1 | Dot-rate clock enable |
| cpu_en | output | 1 | CPU-rate clock enable |
| rom_en | output | 1 | Graphics ROM clock enable |
| sc_phase | output | 6 | Six subcarrier phases, 60 degrees apart |
| burst_out | output | 1 | Gated burst reference phase |
| chroma_on | output | 1 | Loaded code is a chroma color |
| chroma_out | output | 1 | Selected subcarrier phase for the loaded code |
| luma | output | 4 | Gray-scale level of the loaded code |

## Verification
The bench samples every half-cycle so it can catch a phase that moves on the wrong clock edge. A falling-edge register that is missing or mis-reset would put a bit high for two or four half-cycles instead of three, or would shift the odd phases by a full cycle. Release and a second reset taken mid-run check that the enables and phase 0 all restart on the first rising edge. A divider that resets to zero instead of its wrap value would fire one cycle late. The bench also changes the color code on a cycle without a dot enable and changes it back. A selector that loads on every edge would then show a wrong luma, and an off-by-one phase index or gray codes leaking chroma would show up as a chroma mismatch.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int CODE_W   = 4;
  localparam int LUMA_W   = 4;
  localparam int N_PHASE  = 6;
  localparam int N_CHROMA = 6;

  // Gray-scale level attached to each color code
  function automatic logic [LUMA_W-1:0] luma_of(input logic [CODE_W-1:0] c);
    logic [LUMA_W-1:0] v;
    case (c)
      4'd0:    v = 4'd0;
      4'd1:    v = 4'd6;
      4'd2:    v = 4'd9;
      4'd3:    v = 4'd4;
      4'd4:    v = 4'd11;
      4'd5:    v = 4'd7;
      4'd6:    v = 4'd5;
      4'd7:    v = 4'd15;
      default: v = {c[2:0], 1'b1};
    endcase
    return v;
  endfunction

  function automatic logic is_chroma(input logic [CODE_W-1:0] c);
    return (c >= CODE_W'(1)) && (c <= CODE_W'(N_CHROMA));
  endfunction
endpackage

// File: rtl/vcp_timebase.sv
module vcp_timebase #(
  parameter int DOT_DIV = 2,
  parameter int CPU_DIV = 3,
  parameter int ROM_DIV = 24
) (
  input  logic       mclk,
  input  logic       rst_n,
  output logic       started,
  output logic       dot_en,
  output logic       cpu_en,
  output logic       rom_en,
  output logic [1:0] sub_idx
);
  localparam int CW = $clog2(ROM_DIV);
  localparam logic [CW-1:0] WRAP = CW'(ROM_DIV - 1);

  logic [CW-1:0] cnt;

  // Reset to the wrap value so the first rising edge lands on count 0
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= WRAP;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      cnt     <= (cnt == WRAP) ? '0 : cnt + 1'b1;
    end
  end

  assign dot_en  = started && ((cnt % CW'(DOT_DIV)) == '0);
  assign cpu_en  = started && ((cnt % CW'(CPU_DIV)) == '0);
  assign rom_en  = started && (cnt == '0);
  assign sub_idx = 2'(cnt % CW'(3));
endmodule

// File: rtl/vcp_phase6.sv
module vcp_phase6 (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       started,
  input  logic [1:0] sub_idx,
  output logic [5:0] sc_phase
);
  logic [1:0] fall_idx;
  logic [2:0] rise_hot;
  logic [2:0] fall_hot;

  // Falling-edge copy of the mod-3 count; reset value matches half-cycle 0
  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) fall_idx <= 2'd2;
    else        fall_idx <= sub_idx;
  end

  for (genvar j = 0; j < 3; j++) begin : g_ph
    assign rise_hot[j] = (sub_idx == 2'(j));
    assign fall_hot[j] = (fall_idx == 2'(j));
    assign sc_phase[2*j]   = started & (rise_hot[j] | fall_hot[j]);
    assign sc_phase[2*j+1] = started & (fall_hot[j] | rise_hot[(j+1)%3]);
  end
endmodule

// File: rtl/vcp_color_sel.sv
module vcp_color_sel
  import vcp_pkg::*;
#(
  parameter int BURST_PHASE = 3
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              dot_en,
  input  logic [CODE_W-1:0] color_code,
  input  logic [5:0]        sc_phase,
  input  logic              burst_win,
  output logic              chroma_on,
  output logic              chroma_out,
  output logic [LUMA_W-1:0] luma,
  output logic              burst_out
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (dot_en) code_q <= color_code;
  end

  always_comb begin
    chroma_on  = is_chroma(code_q);
    chroma_out = 1'b0;
    for (int i = 0; i < N_CHROMA; i++) begin
      if (code_q == CODE_W'(i + 1)) chroma_out = sc_phase[i];
    end
  end

  assign luma      = luma_of(code_q);
  assign burst_out = burst_win & sc_phase[BURST_PHASE];
endmodule

// File: rtl/vcp_clockgen.sv
module vcp_clockgen #(
  parameter int DOT_DIV     = 2,
  parameter int CPU_DIV     = 3,
  parameter int ROM_DIV     = 24,
  parameter int BURST_PHASE = 3
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [3:0] color_code,
  input  logic       burst_win,
  output logic       dot_en,
  output logic       cpu_en,
  output logic       rom_en,
  output logic [5:0] sc_phase,
  output logic       burst_out,
  output logic       chroma_on,
  output logic       chroma_out,
  output logic [3:0] luma
);
  logic       started;
  logic [1:0] sub_idx;

  vcp_timebase #(.DOT_DIV(DOT_DIV), .CPU_DIV(CPU_DIV), .ROM_DIV(ROM_DIV)) u_tb (
    .mclk(mclk), .rst_n(rst_n), .started(started), .dot_en(dot_en),
    .cpu_en(cpu_en), .rom_en(rom_en), .sub_idx(sub_idx)
  );

  vcp_phase6 u_ph (
    .mclk(mclk), .rst_n(rst_n), .started(started), .sub_idx(sub_idx),
    .sc_phase(sc_phase)
  );

  vcp_color_sel #(.BURST_PHASE(BURST_PHASE)) u_cs (
    .mclk(mclk), .rst_n(rst_n), .dot_en(dot_en), .color_code(color_code),
    .sc_phase(sc_phase), .burst_win(burst_win), .chroma_on(chroma_on),
    .chroma_out(chroma_out), .luma(luma), .burst_out(burst_out)
  );
endmodule

// File: rtl/vcp_clockgen_chk.sv
module vcp_clockgen_chk (
  input logic       mclk,
  input logic       rst_n,
  input logic       dot_en,
  input logic       cpu_en,
  input logic       rom_en,
  input logic [5:0] sc_phase,
  input logic       burst_win,
  input logic       burst_out,
  input logic       chroma_on,
  input logic       chroma_out,
  input logic [3:0] luma
);
  AST_DOT_ALT_OFF: assert property (@(posedge mclk) disable iff (!rst_n) dot_en |=> !dot_en); // R1
  AST_DOT_ALT_ON: assert property (@(posedge mclk) disable iff (!rst_n) !dot_en |=> dot_en); // R1
  AST_CPU_GAP: assert property (@(posedge mclk) disable iff (!rst_n) cpu_en |=> !cpu_en); // R2
  AST_ROM_ALIGN: assert property (@(posedge mclk) disable iff (!rst_n) rom_en |-> (dot_en && cpu_en)); // R3
  AST_PHASE_HALF: assert property (@(posedge mclk) disable iff (!rst_n) (sc_phase != 6'd0) |-> ($countones(sc_phase) == 3)); // R4
  AST_CODE_HOLD: assert property (@(posedge mclk) disable iff (!rst_n) !dot_en |=> ($stable(luma) && $stable(chroma_on))); // R6
  AST_NO_CHROMA: assert property (@(posedge mclk) disable iff (!rst_n) !chroma_on |-> !chroma_out); // R8
  AST_BURST_GATE: assert property (@(posedge mclk) disable iff (!rst_n) !burst_win |-> !burst_out); // R10
endmodule

bind vcp_clockgen vcp_clockgen_chk u_chk (
  .mclk(mclk), .rst_n(rst_n), .dot_en(dot_en), .cpu_en(cpu_en), .rom_en(rom_en),
  .sc_phase(sc_phase), .burst_win(burst_win), .burst_out(burst_out),
  .chroma_on(chroma_on), .chroma_out(chroma_out), .luma(luma)
);

// File: tb/vcp_clockgen_test.sv
`timescale 1ns/1ps
module vcp_clockgen_test;
  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] color_code = 4'd0;
  logic       burst_win = 1'b0;
  logic       dot_en, cpu_en, rom_en, burst_out, chroma_on, chroma_out;
  logic [5:0] sc_phase;
  logic [3:0] luma;

  vcp_clockgen uut (
    .mclk(mclk), .rst_n(rst_n), .color_code(color_code), .burst_win(burst_win),
    .dot_en(dot_en), .cpu_en(cpu_en), .rom_en(rom_en), .sc_phase(sc_phase),
    .burst_out(burst_out), .chroma_on(chroma_on), .chroma_out(chroma_out), .luma(luma)
  );

  always #10 mclk = ~mclk;

  typedef struct { int due; logic [3:0] code; } item_t;
  item_t sb_q[$];

  int n_chk = 0;
  int n_fail = 0;
  int cyc;
  logic [3:0] cur_code = 4'd0;
  logic finished = 1'b0;

  always @(posedge mclk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [5:0] ph_model(input int h);
    logic [5:0] v;
    for (int k = 0; k < 6; k++) v[k] = (((h - k + 6) % 6) < 3);
    return v;
  endfunction

  function automatic logic [3:0] luma_model(input logic [3:0] c);
    int g;
    g = c;
    if (g >= 8) return 4'(2 * (g - 8) + 1);
    case (g)
      1: return 4'd6;  2: return 4'd9;  3: return 4'd4;  4: return 4'd11;
      5: return 4'd7;  6: return 4'd5;  7: return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  // Monitor: samples 6 ns after each edge, pops scoreboard items as they fall due
  task automatic check_half(input bit odd);
    logic [5:0] ph;
    int n;
    if (!rst_n || cyc == 0) begin
      if (!rst_n) cur_code = 4'd0;
      chk("R5 sc_phase", sc_phase, 0);
      chk("R5 enables", {dot_en, cpu_en, rom_en}, 0);
      chk("R5 chroma_out", chroma_out, 0);
      chk("R5 burst_out", burst_out, 0);
      if (!rst_n) chk("R5 luma", luma, 0);
      return;
    end
    n = cyc - 1;
    if (!odd) begin
      if (sb_q.size() > 0 && sb_q[0].due < cyc) begin
        chk("R6 stale scoreboard item", sb_q[0].due, cyc);
        void'(sb_q.pop_front());
      end
      while (sb_q.size() > 0 && sb_q[0].due == cyc) cur_code = sb_q.pop_front().code;
      chk("R1 dot_en", dot_en, (n % 2) == 0);
      chk("R2 cpu_en", cpu_en, (n % 3) == 0);
      chk("R3 rom_en", rom_en, (n % 24) == 0);
    end
    ph = ph_model(2 * (n % 3) + (odd ? 1 : 0));
    chk("R4 sc_phase", sc_phase, ph);
    chk("R10 burst_out", burst_out, burst_win & ph[3]);
    chk("R6 R9 luma", luma, luma_model(cur_code));
    if (cur_code >= 1 && cur_code <= 6) begin
      chk("R7 chroma_on", chroma_on, 1);
      chk("R7 chroma_out", chroma_out, ph[cur_code - 1]);
    end else begin
      chk("R8 chroma_on", chroma_on, 0);
      chk("R8 chroma_out", chroma_out, 0);
    end
  endtask

  initial begin
    forever begin
      @(posedge mclk); #6; check_half(1'b0);
      @(negedge mclk); #6; check_half(1'b1);
    end
  end

  // Driver: apply a code in a dot cycle and push the expected load
  task automatic apply_code(input logic [3:0] c, input int hold);
    item_t it;
    do begin @(posedge mclk); #2; end while (((cyc - 1) % 2) != 0);
    color_code = c;
    it.due = cyc + 1;
    it.code = c;
    sb_q.push_back(it);
    repeat (hold) @(posedge mclk);
  endtask

  // R6: change the code only across an edge without dot enable, then restore it
  task automatic glitch_code(input logic [3:0] c);
    logic [3:0] keep;
    keep = color_code;
    do begin @(posedge mclk); #2; end while (((cyc - 1) % 2) == 0);
    color_code = c;
    @(posedge mclk); #2;
    color_code = keep;
    repeat (3) @(posedge mclk);
  endtask

  initial begin
    forever begin
      @(posedge mclk); #2;
      burst_win = ((cyc / 5) % 2) == 1;
    end
  end

  initial begin
    repeat (3) @(posedge mclk);
    @(negedge mclk); #3 rst_n = 1'b1;
    for (int c = 0; c < 16; c++) apply_code(4'(c), 7);
    apply_code(4'd3, 4);
    glitch_code(4'd12);
    glitch_code(4'd0);
    apply_code(4'd9, 4);
    glitch_code(4'd5);
    repeat (30) @(posedge mclk);
    // R5: reset again mid-run and check the realignment
    @(posedge mclk); #2 rst_n = 1'b0; color_code = 4'd0;
    repeat (3) @(posedge mclk);
    @(negedge mclk); #3 rst_n = 1'b1;
    for (int c = 6; c >= 1; c--) apply_code(4'(c), 5);
    apply_code(4'd7, 30);
    repeat (4) @(posedge mclk);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule